// File: doc/BRIEF.md
# Rate-Adjustable Precision Time Counter

This block keeps a 64-bit time-of-day count for precision time synchronization. Each count is worth 32 ns, so software gets nanoseconds by shifting the count left by five bits. On every reference clock a 32-bit addend is summed into a 32-bit phase accumulator. The carry out of that sum advances the count by one. The nominal addend is 0xA0000000, which gives five counts in every eight clocks, one 32 ns count per 1.6 cycles of a 50 MHz reference.

Software trims the rate only by rewriting the addend. The correction is the nominal value plus or minus nominal × ppb / 10^9, for corrections of up to 50,000,000 ppb in either direction. Software reads, sets and steps the time through a 32-bit register port. The 64-bit value moves through a low word and a high word, and the low word is always accessed first. Reading the low word freezes the high word in a shadow register. Writing the low word only stages it, and the high-word write then loads all 64 bits in one clock. A control bit holds the timing logic in reset. A second control bit opens writes to a limit register, which sets the value at which the low word carries into the high word.

Top module: `ptp_time_counter`

## Requirements
- R1: After rstN is released, control (address 0) reads 0, the addend (address 1) reads 0xA0000000, the low-word limit (address 4) reads 0xFFFFFFFF, and the time count and phase start at zero.
- R2: On every clock the addend is added into a 32-bit phase, and a carry out advances the time count by exactly one. With the nominal addend and the phase at zero after a load, the count is 5 after eight clocks.
- R3: A write to address 1 replaces the addend, reads back unchanged, and sets the new rate at once. With 0x80000000, the count advances once every two clocks.
- R4: Reading the low word (address 2) captures the high word into a shadow. Reading the high word (address 3) returns that shadow, however much the count or the high word has changed since.
- R5: A write to address 2 only stages the low word and does not change the count. A later write to address 3 loads {high data, staged low} into the count in that clock and clears the phase.
- R6: While control bit 0 is 1, the count and phase are held at zero, the addend returns to 0xA0000000, and writes to addresses 1, 2 and 3 are ignored. Counting resumes once the bit is cleared.
- R7: A write to address 4 takes effect only while control bit 1 is 1. Otherwise it is ignored.
- R8: When a count step falls while the low word is at or above the limit, the low word returns to 0 and the high word increments.
- R9: Read data appears on rdData one clock after the cycle in which rdEn is high. An address outside 0 to 4 reads 0, and control reads as bit 0 soft reset and bit 1 limit write enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, registered |

## Verification
A phase accumulator that holds a wrong value shows at the ports only as a count that drifts away from the expected rate. It can take several clocks before a carry lands on the wrong edge and a low-word read disagrees with the model. For that reason the bench checks exact counts over fixed windows right after a load, when the phase is known to be zero. A wrong shadow or staging register shows up on the very next high-word read or time load. A faulty limit or carry shows up on the first read of the high word after the low word passes its limit.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;

  localparam int unsigned REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    ADDR_CTRL    = 3'd0,
    ADDR_ADDEND  = 3'd1,
    ADDR_TIME_LO = 3'd2,
    ADDR_TIME_HI = 3'd3,
    ADDR_LIMIT   = 3'd4
  } regAddr_e;

  localparam int unsigned CTRL_SOFT_RST = 0;
  localparam int unsigned CTRL_LIM_WEN  = 1;
  localparam int unsigned CTRL_W        = 2;

  // strobes from the register control to the time datapath
  typedef struct packed {
    logic clearAll;
    logic loadTime;
  } dpStrobe_t;

endpackage

// File: rtl/ptp_tc_datapath.sv
module ptp_tc_datapath
  import ptp_tc_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned TIME_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [TIME_W-1:0] loadValue,
  input  logic [WORD_W-1:0] addend,
  input  logic [WORD_W-1:0] lowLimit,
  output logic [WORD_W-1:0] timeLo,
  output logic [WORD_W-1:0] timeHi
);

  logic [WORD_W-1:0] phase;
  logic [WORD_W:0]   phaseSum;
  logic              tick;
  logic              lowWrap;

  assign phaseSum = {1'b0, phase} + {1'b0, addend};
  assign tick     = phaseSum[WORD_W];
  assign lowWrap  = (timeLo >= lowLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= '0;
      timeLo <= '0;
      timeHi <= '0;
    end else if (strobe.clearAll) begin
      phase  <= '0;
      timeLo <= '0;
      timeHi <= '0;
    end else if (strobe.loadTime) begin
      phase  <= '0;
      timeLo <= loadValue[WORD_W-1:0];
      timeHi <= loadValue[TIME_W-1:WORD_W];
    end else begin
      phase <= phaseSum[WORD_W-1:0];
      if (tick) begin
        if (lowWrap) begin
          timeLo <= '0;
          timeHi <= timeHi + 1'b1;
        end else begin
          timeLo <= timeLo + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ptp_tc_control.sv
module ptp_tc_control
  import ptp_tc_pkg::*;
#(
  parameter int unsigned      WORD_W         = 32,
  parameter logic [WORD_W-1:0] NOMINAL_ADDEND = 32'hA000_0000,
  parameter logic [WORD_W-1:0] LIMIT_RESET    = '1,
  localparam int unsigned     TIME_W         = 2 * WORD_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0]     wrData,
  input  logic [WORD_W-1:0]     timeLo,
  input  logic [WORD_W-1:0]     timeHi,
  output dpStrobe_t             strobe,
  output logic [TIME_W-1:0]     loadValue,
  output logic [WORD_W-1:0]     addendVal,
  output logic [WORD_W-1:0]     limitVal,
  output logic [WORD_W-1:0]     rdData
);

  logic [CTRL_W-1:0] ctrlReg;
  logic [WORD_W-1:0] stageLo;
  logic [WORD_W-1:0] shadowHi;
  logic              softRst;
  logic              limWrOpen;
  regAddr_e          regSel;

  assign softRst   = ctrlReg[CTRL_SOFT_RST];
  assign limWrOpen = ctrlReg[CTRL_LIM_WEN];
  assign regSel    = regAddr_e'(addr);

  assign strobe.clearAll = softRst;
  assign strobe.loadTime = wrEn && (regSel == ADDR_TIME_HI) && !softRst;
  assign loadValue       = {wrData, stageLo};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      addendVal <= NOMINAL_ADDEND;
      limitVal  <= LIMIT_RESET;
      stageLo   <= '0;
    end else begin
      if (wrEn) begin
        case (regSel)
          ADDR_CTRL:    ctrlReg <= wrData[CTRL_W-1:0];
          ADDR_ADDEND:  if (!softRst) addendVal <= wrData;
          ADDR_TIME_LO: if (!softRst) stageLo <= wrData;
          ADDR_LIMIT:   if (limWrOpen) limitVal <= wrData;
          default: ;
        endcase
      end
      if (softRst) addendVal <= NOMINAL_ADDEND;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData   <= '0;
      shadowHi <= '0;
    end else if (rdEn) begin
      case (regSel)
        ADDR_CTRL:    rdData <= {{(WORD_W-CTRL_W){1'b0}}, ctrlReg};
        ADDR_ADDEND:  rdData <= addendVal;
        ADDR_TIME_LO: begin
          rdData   <= timeLo;
          shadowHi <= timeHi;
        end
        ADDR_TIME_HI: rdData <= shadowHi;
        ADDR_LIMIT:   rdData <= limitVal;
        default:      rdData <= '0;
      endcase
    end
  end

endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptp_tc_pkg::*;
#(
  parameter int unsigned      WORD_W         = 32,
  parameter logic [WORD_W-1:0] NOMINAL_ADDEND = 32'hA000_0000,
  parameter logic [WORD_W-1:0] LIMIT_RESET    = '1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0]     wrData,
  output logic [WORD_W-1:0]     rdData
);

  localparam int unsigned TIME_W = 2 * WORD_W;

  dpStrobe_t         dpStrobe;
  logic [TIME_W-1:0] loadValue;
  logic [WORD_W-1:0] addendVal;
  logic [WORD_W-1:0] limitVal;
  logic [WORD_W-1:0] timeLo;
  logic [WORD_W-1:0] timeHi;

  ptp_tc_control #(
    .WORD_W         (WORD_W),
    .NOMINAL_ADDEND (NOMINAL_ADDEND),
    .LIMIT_RESET    (LIMIT_RESET)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .addr      (addr),
    .wrData    (wrData),
    .timeLo    (timeLo),
    .timeHi    (timeHi),
    .strobe    (dpStrobe),
    .loadValue (loadValue),
    .addendVal (addendVal),
    .limitVal  (limitVal),
    .rdData    (rdData)
  );

  ptp_tc_datapath #(
    .WORD_W (WORD_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (dpStrobe),
    .loadValue (loadValue),
    .addend    (addendVal),
    .lowLimit  (limitVal),
    .timeLo    (timeLo),
    .timeHi    (timeHi)
  );

endmodule

// File: rtl/ptp_tc_checker.sv
module ptp_tc_checker
  import ptp_tc_pkg::*;
#(
  parameter int unsigned      WORD_W         = 32,
  parameter logic [WORD_W-1:0] NOMINAL_ADDEND = 32'hA000_0000,
  localparam int unsigned     TIME_W         = 2 * WORD_W
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  clearAll,
  input logic                  loadTime,
  input logic [TIME_W-1:0]     loadValue,
  input logic [WORD_W-1:0]     timeLo,
  input logic [WORD_W-1:0]     timeHi,
  input logic [WORD_W-1:0]     addendVal,
  input logic                  rdEn,
  input logic [REG_ADDR_W-1:0] addr,
  input logic [WORD_W-1:0]     rdData
);

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    clearAll |=> (timeLo == '0 && timeHi == '0)); // R6

  AST_ADDEND_NOMINAL: assert property (@(posedge clk) disable iff (!rstN)
    clearAll |=> (addendVal == NOMINAL_ADDEND)); // R6

  AST_LOAD_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    (loadTime && !clearAll) |=> ({timeHi, timeLo} == $past(loadValue))); // R5

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (!clearAll && !loadTime) |=>
      ((timeHi == $past(timeHi) && (timeLo - $past(timeLo)) <= 1) ||
       (timeHi == $past(timeHi) + 1'b1 && timeLo == '0))); // R2

  AST_LO_READ: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_TIME_LO) |=> (rdData == $past(timeLo))); // R9

endmodule

bind ptp_time_counter ptp_tc_checker #(
  .WORD_W         (WORD_W),
  .NOMINAL_ADDEND (NOMINAL_ADDEND)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .clearAll  (dpStrobe.clearAll),
  .loadTime  (dpStrobe.loadTime),
  .loadValue (loadValue),
  .timeLo    (timeLo),
  .timeHi    (timeHi),
  .addendVal (addendVal),
  .rdEn      (rdEn),
  .addr      (addr),
  .rdData    (rdData)
);

// File: tb/ptp_time_counter_tb.sv
module ptp_time_counter_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;

  int checks = 0;
  int fails  = 0;
  string curReq = "R1";
  bit done = 1'b0;

  always #10 clk = ~clk;

  ptp_time_counter u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  // behavioural reference model
  logic [1:0]  mCtrl;
  logic [31:0] mAdd, mLim, mStage, mShadow, mRd, mLo, mHi;
  longint      mPh;
  bit          rdPend = 1'b0;

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = 0; mAdd = 32'hA000_0000; mLim = 32'hFFFF_FFFF;
      mStage = 0; mShadow = 0; mRd = 0; mLo = 0; mHi = 0; mPh = 0;
      rdPend = 1'b0;
    end else begin
      rdPend = rdEn;
      if (rdEn) begin
        case (addr)
          3'd0: mRd = {30'd0, mCtrl};
          3'd1: mRd = mAdd;
          3'd2: begin mRd = mLo; mShadow = mHi; end
          3'd3: mRd = mShadow;
          3'd4: mRd = mLim;
          default: mRd = 0;
        endcase
      end
      if (mCtrl[0]) begin
        mPh = 0; mLo = 0; mHi = 0;
      end else if (wrEn && addr == 3'd3) begin
        mPh = 0; mLo = mStage; mHi = wrData;
      end else begin
        mPh = mPh + longint'({32'd0, mAdd});
        if (mPh >= 64'h1_0000_0000) begin
          mPh = mPh - 64'h1_0000_0000;
          if (mLo >= mLim) begin mLo = 0; mHi = mHi + 1; end
          else mLo = mLo + 1;
        end
      end
      if (wrEn) begin
        case (addr)
          3'd1: if (!mCtrl[0]) mAdd = wrData;
          3'd2: if (!mCtrl[0]) mStage = wrData;
          3'd4: if (mCtrl[1]) mLim = wrData;
          default: ;
        endcase
      end
      if (mCtrl[0]) mAdd = 32'hA000_0000;
      if (wrEn && addr == 3'd0) mCtrl = wrData[1:0];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-read comparison against the model
  always @(negedge clk) begin
    if (rstN && rdPend && !done) chk({curReq, " model"}, rdData, mRd);
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic rdChk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    curReq = tag;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] tmp;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset values
    rdChk(3'd0, 32'd0, "R1");
    rdChk(3'd1, 32'hA000_0000, "R1");
    rdChk(3'd4, 32'hFFFF_FFFF, "R1");
    // R2 nominal rate: five counts in eight clocks after a load
    curReq = "R2";
    wr(3'd3, 32'd0);
    repeat (8) @(negedge clk);
    rdChk(3'd2, 32'd5, "R2");
    // R5 staged low word, load on high write
    curReq = "R5";
    wr(3'd2, 32'hFFFF_FFF0);
    repeat (4) @(negedge clk);
    rd(3'd2, tmp);
    wr(3'd3, 32'h12);
    rdChk(3'd2, 32'hFFFF_FFF0, "R5");
    rdChk(3'd3, 32'h12, "R4");
    // R8 carry of a full-range low word
    curReq = "R8";
    repeat (30) @(negedge clk);
    rd(3'd2, tmp);
    rdChk(3'd3, 32'h13, "R8");
    // R4 shadow is unchanged by a later high write without a low read
    curReq = "R4";
    wr(3'd3, 32'h77);
    rdChk(3'd3, 32'h13, "R4");
    // R7 limit write gating
    curReq = "R7";
    wr(3'd4, 32'h100);
    rdChk(3'd4, 32'hFFFF_FFFF, "R7");
    wr(3'd0, 32'd2);
    wr(3'd4, 32'h20);
    wr(3'd0, 32'd0);
    rdChk(3'd4, 32'h20, "R7");
    // R8 carry at a short limit
    curReq = "R8";
    wr(3'd2, 32'h1C);
    wr(3'd3, 32'd5);
    repeat (20) @(negedge clk);
    rd(3'd2, tmp);
    rdChk(3'd3, 32'd6, "R8");
    wr(3'd0, 32'd2);
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd0, 32'd0);
    // R3 addend reprogramming: one count every two clocks
    curReq = "R3";
    wr(3'd1, 32'h8000_0000);
    rdChk(3'd1, 32'h8000_0000, "R3");
    wr(3'd2, 32'd0);
    wr(3'd3, 32'd0);
    repeat (10) @(negedge clk);
    rdChk(3'd2, 32'd5, "R3");
    // R6 soft reset hold
    curReq = "R6";
    wr(3'd0, 32'd1);
    @(negedge clk);
    rdChk(3'd2, 32'd0, "R6");
    rdChk(3'd1, 32'hA000_0000, "R6");
    wr(3'd1, 32'h1234);
    rdChk(3'd1, 32'hA000_0000, "R6");
    wr(3'd2, 32'd5);
    wr(3'd3, 32'd7);
    rdChk(3'd2, 32'd0, "R6");
    rdChk(3'd3, 32'd0, "R6");
    wr(3'd0, 32'd0);
    repeat (9) @(negedge clk);
    rdChk(3'd2, 32'd5, "R6");
    // R9 control layout and unused address
    rdChk(3'd0, 32'd0, "R9");
    rdChk(3'd5, 32'd0, "R9");
    wr(3'd0, 32'd2);
    rdChk(3'd0, 32'd2, "R9");
    wr(3'd0, 32'd0);
    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule